// File: doc/BRIEF.md
# Framed Master Serial Word Transmitter

This block sends fixed-width words over a three-wire serial link and acts as the clock master. All of its timing comes from one input clock. It makes a bit clock at half that rate, a serial data line, and a frame-sync line. Every frame lasts 64 input clocks (32 bit periods). The word goes out most significant bit first during the first half of the frame, and the line carries zeros during the second half.

Two select inputs set the framing. The frame-style select picks between a frame sync that pulses high for one bit period and a frame sync that is a square wave, low for the data half and high for the zero half. The clock-phase select inverts the bit clock for whichever style is chosen. This decides which bit-clock edge launches data and which edge the receiver samples on.

The data driver is enabled only while the output-enable input matches the side-select input. This lets two transmitters take turns on one shared line. The block does not drive a tri-state pad. It reports the high-impedance condition on a separate drive-enable output. A word given with the load strobe is held and moved into the shifter only at a frame boundary.

Top module: `framed_word_tx`

## Requirements
- R1: While reset is asserted, bclk_o, sdata_o and sdata_oe_o's companion data are quiet: bclk_o is 0 and sdata_o is 0. After reset, bclk_o changes level on every input clock, so it runs at half the input clock rate.
- R2: The first frame begins in the first input clock after reset is released. Every later frame begins exactly 64 input clocks after the one before it. Frame clocks are numbered 0 to 63.
- R3: During frame clocks 2k and 2k+1, for k from 0 to 15, sdata_o carries bit 15-k of the word (MSB first). During frame clocks 32 to 63, sdata_o is 0.
- R4: With frame_sel_i = 0 (pulse style), fsync_o is 1 only in frame clocks 0 and 1, and is 0 during reset.
- R5: With frame_sel_i = 1 (square style), fsync_o is 0 in frame clocks 0 to 31 and 1 in frame clocks 32 to 63. It is 1 during reset.
- R6: bclk_o is 1 in even frame clocks and 0 in odd frame clocks when frame_sel_i equals phase_sel_i. The levels are the reverse when the two selects differ. Data changes only at the start of an even frame clock.
- R7: sdata_oe_o is 1 exactly when oe_i equals side_i, and it follows the inputs within the same cycle.
- R8: At the clock edge that starts a frame, the shifter takes the word from a load at that edge if load_i is 1. Otherwise it takes the most recently loaded word. A load in the middle of a frame does not change the frame in progress. With no new load, the last word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_i | input | 16 | Word to transmit |
| load_i | input | 1 | Strobe that captures word_i |
| frame_sel_i | input | 1 | Frame style: 0 pulse, 1 square |
| phase_sel_i | input | 1 | Inverts the bit-clock phase |
| oe_i | input | 1 | Output-enable input |
| side_i | input | 1 | Level of oe_i at which this transmitter drives |
| bclk_o | output | 1 | Bit clock, half the input clock rate |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Drive enable for the data line |
| fsync_o | output | 1 | Frame sync |

## Verification
Every output is decoded from registers that update at the rising edge, so a new level appears one input clock after the edge that causes it. Frame clock 0 is therefore the cycle that follows the first edge after reset is released. The bench drives inputs and samples outputs on falling edges, and it counts frame clocks from that first cycle. A word loaded with a strobe at frame clock n is due in the next frame, never in the current one. The drive enable is combinational, so it is checked a moment after oe_i or side_i change, with no clock edge in between.

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  input  logic              frame_sel_i,
  input  logic              phase_sel_i,
  input  logic              oe_i,
  input  logic              side_i,
  output logic              bclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              fsync_o
);
  localparam int FRAME_CLKS = 4 * WORD_W;
  localparam int CNT_W = $clog2(FRAME_CLKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(2 * WORD_W);
  localparam logic [CNT_W-1:0] ONE_BIT = CNT_W'(2);

  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] shreg;
  logic              boundary;
  logic              in_data;

  assign boundary = !run || (cnt == LAST);
  assign in_data  = cnt < HALF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      run   <= 1'b0;
      hold  <= '0;
      shreg <= '0;
    end else begin
      run <= 1'b1;
      if (load_i) hold <= word_i;
      if (boundary) begin
        cnt   <= '0;
        shreg <= load_i ? word_i : hold;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt[0]) shreg <= {shreg[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign bclk_o     = run & (cnt[0] ^ ~(frame_sel_i ^ phase_sel_i));
  assign sdata_o    = run & in_data & shreg[WORD_W-1];
  assign sdata_oe_o = (oe_i == side_i);
  assign fsync_o    = frame_sel_i ? (!run || !in_data) : (run && cnt < ONE_BIT);

  AST_BCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && $stable(frame_sel_i) && $stable(phase_sel_i) |-> bclk_o != $past(bclk_o)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && cnt[0] |-> $stable(sdata_o)); // R6
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run && frame_sel_i && fsync_o |-> !sdata_o); // R3
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sel_i && $rose(fsync_o) |=> fsync_o); // R4
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sel_i && $rose(fsync_o) |=> ##1 !fsync_o); // R4
  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(side_i) && $stable(oe_i) |-> sdata_oe_o != $past(sdata_oe_o)); // R7
endmodule

// File: tb/framed_word_tx_bench.sv
module framed_word_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_i = '0;
  logic        load_i = 1'b0;
  logic        frame_sel_i = 1'b0;
  logic        phase_sel_i = 1'b0;
  logic        oe_i = 1'b0;
  logic        side_i = 1'b0;
  logic        bclk_o, sdata_o, sdata_oe_o, fsync_o;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  framed_word_tx u_framed_word_tx (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .load_i(load_i),
    .frame_sel_i(frame_sel_i), .phase_sel_i(phase_sel_i), .oe_i(oe_i), .side_i(side_i),
    .bclk_o(bclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .fsync_o(fsync_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Entered at the falling edge in frame clock 0; leaves at frame clock 0 of the next frame.
  task automatic check_frame(input logic [15:0] word, input logic fs, input logic ph,
                             input int ld_at, input logic [15:0] ld_word);
    int bad_clk = 0, bad_fs = 0, bad_dat = 0;
    frame_sel_i = fs;
    phase_sel_i = ph;
    for (int i = 0; i < 64; i++) begin
      logic eb, ef, ed;
      if (i == ld_at) begin
        load_i = 1'b1;
        word_i = ld_word;
      end else begin
        load_i = 1'b0;
      end
      #1;
      eb = (i % 2 == 0) ? (fs == ph) : (fs != ph);
      ef = fs ? (i >= 32) : (i < 2);
      ed = (i < 32) ? word[15 - i / 2] : 1'b0;
      if (bclk_o !== eb && bad_clk++ == 0)
        $display("FAIL R1/R6 bclk at clock %0d: actual %b expected %b", i, bclk_o, eb);
      if (fsync_o !== ef && bad_fs++ == 0)
        $display("FAIL %s/R2 fsync at clock %0d: actual %b expected %b", fs ? "R5" : "R4", i, fsync_o, ef);
      if (sdata_o !== ed && bad_dat++ == 0)
        $display("FAIL R3/R8 data at clock %0d: actual %b expected %b", i, sdata_o, ed);
      @(negedge clk);
    end
    load_i = 1'b0;
    checks += 3;
    errors += (bad_clk != 0) + (bad_fs != 0) + (bad_dat != 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    #1;
    check("R1 bclk in reset", bclk_o, 1'b0);
    check("R1 data in reset", sdata_o, 1'b0);
    check("R4 fsync pulse style in reset", fsync_o, 1'b0);
    frame_sel_i = 1'b1;
    #1;
    check("R5 fsync square style in reset", fsync_o, 1'b1);
    frame_sel_i = 1'b0;
  endtask

  task automatic test_start();
    word_i = 16'hA5C3;
    load_i = 1'b1;
    rst_n  = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    #1;
    check("R2 frame starts first clock after reset", fsync_o, 1'b1);
  endtask

  task automatic test_drive();
    for (int k = 0; k < 4; k++) begin
      oe_i   = k[0];
      side_i = k[1];
      #1;
      check("R7 drive enable", sdata_oe_o, k[0] == k[1]);
    end
  endtask

  initial begin
    test_reset();
    test_start();
    check_frame(16'hA5C3, 1'b0, 1'b0, 20, 16'h3C96);  // R8 mid-frame load waits
    check_frame(16'h3C96, 1'b0, 1'b1, -1, 16'h0000);  // R6 inverted phase
    check_frame(16'h3C96, 1'b1, 1'b0, 63, 16'h8001);  // R8 resend, load at boundary
    check_frame(16'h8001, 1'b1, 1'b1, -1, 16'h0000);  // R5 square, R6
    check_frame(16'h8001, 1'b0, 1'b0, -1, 16'h0000);  // R2 steady frame period
    test_drive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule